// File: doc/BRIEF.md
# Soft Reset and FIFO Flush Controller

This block holds a 32-bit control and status word with the sequencing logic behind it. Software sets request bits in the word to start a core soft reset, a reset of the full-speed controller, a reset of the host frame counter, a transmit FIFO flush, or a receive FIFO flush. Each request bit clears itself when its action has finished. Software polls the word to see when that happens.

The two flush requests and the frame counter reset run on a fixed cycle count. Each is sequenced by a `flush_timer` state machine with the states FT_IDLE, FT_COUNT and FT_DONE:
- FT_IDLE goes to FT_COUNT on a start.
- FT_COUNT goes to FT_DONE when its counter reaches the last cycle.
- FT_DONE goes to FT_COUNT on a new start, or back to FT_IDLE.

The soft resets last a variable time. Each is sequenced by a `req_ack_fsm` with the states RA_IDLE, RA_WAIT, RA_ACTIVE and RA_CLEAR:
- RA_IDLE goes to RA_WAIT on a start when gating on the bus-master idle input. Without that gating it goes straight to RA_ACTIVE.
- RA_WAIT goes to RA_ACTIVE once the bus master is idle.
- RA_ACTIVE goes to RA_CLEAR on the downstream acknowledge.
- RA_CLEAR behaves like RA_IDLE for one cycle.

A 5-bit selector picks which transmit FIFO a flush targets. Codes below the FIFO count pick one FIFO. Code 0x10 picks all of them.

Top module: `rst_flush_ctrl`

## Requirements
- R1: After reset the word reads 0x8000_0000 while the bus-master idle input is 1. Bit 31 always shows the bus-master idle input and bit 30 always shows the DMA-busy input.
- R2: The selector sits in bits 10:6 and is decoded onto `txf_sel` while a transmit flush runs. Codes 0–15 set only bit `code`, code 16 sets every bit, and codes 17–31 set no bit.
- R3: Writing 1 to bit 5 holds `txf_flush` high for exactly 8 cycles. The cycle after that, `txf_done` is high for one cycle and bit 5 reads 0.
- R4: Writing 1 to bit 4 holds `rxf_flush` high for exactly 8 cycles. The cycle after that, `rxf_done` is high for one cycle and bit 4 reads 0.
- R5: A write to bits 10:6 while bit 5 reads 1 leaves the selector unchanged.
- R6: Writing 1 to a request bit that is already set does not restart its timer, and writing 0 to a set request bit does not clear it.
- R7: Writing 1 to bit 2 drives `frm_rst` high for 3 cycles, with bit 2 reading 1 during that time and 0 afterwards.
- R8: Writing 1 to bit 1 drives `fs_rst` high and keeps bit 1 at 1 until `fs_ack` is seen. In the cycle after the acknowledge, both read 0.
- R9: After bit 0 is written to 1, `core_rst` stays low and bit 0 stays 1 for as long as the bus-master idle input is 0, so that the transfer in progress can finish its data phase.
- R10: While `core_rst` is high, `txf_flush` and `rxf_flush` are high and `txf_sel` is all ones. In the cycle after `core_ack`, `core_rst` and bit 0 read 0.
- R11: Bits 29:11 and bit 3 always read 0, whatever is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the control word |
| mst_idle | input | 1 | Bus master is idle |
| dma_busy | input | 1 | A DMA request is in progress |
| txf_flush | output | 1 | Transmit flush strobe |
| txf_sel | output | NUM_TXF | Transmit FIFOs to flush, one bit each |
| txf_done | output | 1 | One-cycle end-of-flush pulse, transmit side |
| rxf_flush | output | 1 | Receive flush strobe |
| rxf_done | output | 1 | One-cycle end-of-flush pulse, receive side |
| frm_rst | output | 1 | Host frame counter reset |
| fs_rst | output | 1 | Full-speed controller reset |
| fs_ack | input | 1 | Full-speed controller reset finished |
| core_rst | output | 1 | Core soft reset to downstream domains |
| core_ack | input | 1 | Downstream core reset finished |

## Verification
The bench sweeps all 32 selector codes. A decode that mishandled the all-FIFOs code or the unused codes 17–31 would flush the wrong FIFOs. It measures the exact strobe length in cycles, which exposes an off-by-one counter that flushes for 7 or 9 cycles. It rewrites the selector and the request bit in the middle of a flush: a design that let the selector slip would retarget a flush already running, and one that restarted the timer would stretch it. It holds the bus-master idle input low across a core reset request, which catches a design that cuts a bus transfer short. It also withholds acknowledges to confirm that the soft-reset bits do not clear early.

// File: rtl/srfc_pkg.sv
`timescale 1ns/1ps
package srfc_pkg;
    localparam int SEL_W    = 5;
    localparam int SEL_LSB  = 6;
    localparam logic [SEL_W-1:0] SEL_ALL = 5'h10;

    localparam int B_CORE   = 0;
    localparam int B_FS     = 1;
    localparam int B_FRM    = 2;
    localparam int B_RXF    = 4;
    localparam int B_TXF    = 5;
    localparam int B_DMA    = 30;
    localparam int B_IDLE   = 31;

    typedef enum logic [1:0] {
        FT_IDLE,
        FT_COUNT,
        FT_DONE
    } ft_state_e;

    typedef enum logic [1:0] {
        RA_IDLE,
        RA_WAIT,
        RA_ACTIVE,
        RA_CLEAR
    } ra_state_e;
endpackage

// File: rtl/flush_timer.sv
`timescale 1ns/1ps
module flush_timer
    import srfc_pkg::*;
#(
    parameter int CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic strobe,
    output logic done
);
    localparam int CNT_W = (CYCLES > 2) ? $clog2(CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

    ft_state_e        state, nxt;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FT_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt <= '0;
        else if (state != FT_COUNT) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            FT_IDLE:  if (start) nxt = FT_COUNT;
            FT_COUNT: if (cnt == LAST) nxt = FT_DONE;
            FT_DONE:  nxt = start ? FT_COUNT : FT_IDLE;
            default:  nxt = FT_IDLE;
        endcase
    end

    always_comb begin
        strobe = (state == FT_COUNT);
        busy   = (state == FT_COUNT);
        done   = (state == FT_DONE);
    end

    // R3
    done_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(strobe));
    // R6
    strobe_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe) |-> $past(start));
endmodule

// File: rtl/req_ack_fsm.sv
`timescale 1ns/1ps
module req_ack_fsm
    import srfc_pkg::*;
#(
    parameter bit GATE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic idle_in,
    input  logic ack,
    output logic busy,
    output logic req
);
    ra_state_e state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RA_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            RA_IDLE, RA_CLEAR: begin
                if (start)            nxt = GATE ? RA_WAIT : RA_ACTIVE;
                else                  nxt = RA_IDLE;
            end
            RA_WAIT:   if (idle_in) nxt = RA_ACTIVE;
            RA_ACTIVE: if (ack)     nxt = RA_CLEAR;
            default:                nxt = RA_IDLE;
        endcase
    end

    always_comb begin
        busy = (state == RA_WAIT) || (state == RA_ACTIVE);
        req  = (state == RA_ACTIVE);
    end

    // R9
    gate_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (GATE && $rose(req)) |-> $past(idle_in));
    // R8
    hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack) |=> req);
endmodule

// File: rtl/txf_decode.sv
`timescale 1ns/1ps
module txf_decode
    import srfc_pkg::*;
#(
    parameter int NUM_TXF = 16
) (
    input  logic [SEL_W-1:0]   code,
    output logic [NUM_TXF-1:0] vec
);
    logic all_hit;
    assign all_hit = (code == SEL_ALL);

    for (genvar i = 0; i < NUM_TXF; i++) begin : g_bit
        assign vec[i] = all_hit || (code == SEL_W'(i));
    end
endmodule

// File: rtl/rst_flush_ctrl.sv
`timescale 1ns/1ps
module rst_flush_ctrl
    import srfc_pkg::*;
#(
    parameter int NUM_TXF    = 16,
    parameter int TXF_CYCLES = 8,
    parameter int RXF_CYCLES = 8,
    parameter int FRM_CYCLES = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               mst_idle,
    input  logic               dma_busy,
    output logic               txf_flush,
    output logic [NUM_TXF-1:0] txf_sel,
    output logic               txf_done,
    output logic               rxf_flush,
    output logic               rxf_done,
    output logic               frm_rst,
    output logic               fs_rst,
    input  logic               fs_ack,
    output logic               core_rst,
    input  logic               core_ack
);
    logic [SEL_W-1:0]   sel_q;
    logic [NUM_TXF-1:0] sel_vec;
    logic tx_busy, tx_strobe, rx_busy, rx_strobe;
    logic frm_busy, frm_done, fs_busy, cr_busy;
    logic unused_wbits;

    assign unused_wbits = ^{reg_wdata[31:11], reg_wdata[3]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                sel_q <= '0;
        else if (reg_wr && !tx_busy) sel_q <= reg_wdata[SEL_LSB +: SEL_W];
    end

    flush_timer #(.CYCLES(TXF_CYCLES)) u_tx (
        .clk(clk), .rst_n(rst_n), .start(reg_wr && reg_wdata[B_TXF]),
        .busy(tx_busy), .strobe(tx_strobe), .done(txf_done));

    flush_timer #(.CYCLES(RXF_CYCLES)) u_rx (
        .clk(clk), .rst_n(rst_n), .start(reg_wr && reg_wdata[B_RXF]),
        .busy(rx_busy), .strobe(rx_strobe), .done(rxf_done));

    flush_timer #(.CYCLES(FRM_CYCLES)) u_frm (
        .clk(clk), .rst_n(rst_n), .start(reg_wr && reg_wdata[B_FRM]),
        .busy(frm_busy), .strobe(frm_rst), .done(frm_done));

    req_ack_fsm #(.GATE(1'b0)) u_fs (
        .clk(clk), .rst_n(rst_n), .start(reg_wr && reg_wdata[B_FS]),
        .idle_in(mst_idle), .ack(fs_ack), .busy(fs_busy), .req(fs_rst));

    req_ack_fsm #(.GATE(1'b1)) u_core (
        .clk(clk), .rst_n(rst_n), .start(reg_wr && reg_wdata[B_CORE]),
        .idle_in(mst_idle), .ack(core_ack), .busy(cr_busy), .req(core_rst));

    txf_decode #(.NUM_TXF(NUM_TXF)) u_dec (.code(sel_q), .vec(sel_vec));

    always_comb begin
        txf_flush = tx_strobe || core_rst;
        rxf_flush = rx_strobe || core_rst;
        if (core_rst)       txf_sel = '1;
        else if (tx_strobe) txf_sel = sel_vec;
        else                txf_sel = '0;
    end

    always_comb begin
        reg_rdata                     = '0;
        reg_rdata[B_IDLE]             = mst_idle;
        reg_rdata[B_DMA]              = dma_busy;
        reg_rdata[SEL_LSB +: SEL_W]   = sel_q;
        reg_rdata[B_TXF]              = tx_busy;
        reg_rdata[B_RXF]              = rx_busy;
        reg_rdata[B_FRM]              = frm_busy;
        reg_rdata[B_FS]               = fs_busy;
        reg_rdata[B_CORE]             = cr_busy;
    end

    // R5
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy && $past(tx_busy)) |-> $stable(sel_q));
    // R2
    sel_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_strobe && !core_rst && (sel_q < SEL_W'(NUM_TXF))) |-> ($countones(txf_sel) == 1));
    // R7
    frm_done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done |-> !reg_rdata[B_FRM]);
    // R10
    core_flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst |-> (txf_flush && rxf_flush && (&txf_sel)));
endmodule

// File: tb/rst_flush_ctrl_test.sv
`timescale 1ns/1ps
module rst_flush_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mst_idle = 1'b1;
    logic        dma_busy = 1'b0;
    logic        txf_flush, txf_done, rxf_flush, rxf_done;
    logic [15:0] txf_sel;
    logic        frm_rst, fs_rst, core_rst;
    logic        fs_ack = 1'b0;
    logic        core_ack = 1'b0;
    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rst_flush_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .mst_idle(mst_idle), .dma_busy(dma_busy),
        .txf_flush(txf_flush), .txf_sel(txf_sel), .txf_done(txf_done),
        .rxf_flush(rxf_flush), .rxf_done(rxf_done), .frm_rst(frm_rst),
        .fs_rst(fs_rst), .fs_ack(fs_ack), .core_rst(core_rst), .core_ack(core_ack));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] v);
        reg_wr = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic wait_low(ref logic s);
        for (int k = 0; k < 40 && s; k++) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int c0;
        logic [15:0] exp_sel;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset value and live status bits
        chk("R1 reset", reg_rdata, 32'h8000_0000);
        dma_busy = 1'b1; mst_idle = 1'b0;
        #1 chk("R1 status", reg_rdata, 32'h4000_0000);
        dma_busy = 1'b0; mst_idle = 1'b1;
        @(negedge clk);

        // R11 reserved bits
        wr(32'hFFFF_F808);
        chk("R11 reserved", reg_rdata, 32'h8000_0000);

        // R2 / R3 sweep every selector code
        for (int code = 0; code < 32; code++) begin
            exp_sel = (code < 16) ? (16'h1 << code) : ((code == 16) ? 16'hFFFF : 16'h0);
            wr((32'(code) << 6) | 32'h20);
            c0 = cyc;
            chk("R2 decode", {16'h0, txf_sel}, {16'h0, exp_sel});
            chk("R2 sel readback", {27'h0, reg_rdata[10:6]}, 32'(code));
            wait_low(txf_flush);
            chk("R3 strobe length", 32'(cyc - c0), 32'd8);
            chk("R3 done pulse", {31'h0, txf_done}, 32'd1);
            chk("R3 bit clears", {31'h0, reg_rdata[5]}, 32'd0);
            @(negedge clk);
            chk("R3 single done", {31'h0, txf_done}, 32'd0);
        end

        // R5 / R6 selector held, no restart, write 0 no effect
        wr((32'd3 << 6) | 32'h20);
        c0 = cyc;
        @(negedge clk);
        wr((32'd9 << 6) | 32'h20);
        chk("R5 sel held", {27'h0, reg_rdata[10:6]}, 32'd3);
        chk("R5 target held", {16'h0, txf_sel}, 32'h0008);
        wr(32'h0);
        chk("R6 write0 no effect", {31'h0, reg_rdata[5]}, 32'd1);
        wait_low(txf_flush);
        chk("R6 no restart", 32'(cyc - c0), 32'd8);
        @(negedge clk);

        // R4 receive flush
        wr(32'h10);
        c0 = cyc;
        chk("R4 bit set", {31'h0, reg_rdata[4]}, 32'd1);
        wait_low(rxf_flush);
        chk("R4 strobe length", 32'(cyc - c0), 32'd8);
        chk("R4 done pulse", {31'h0, rxf_done}, 32'd1);
        chk("R4 bit clears", {31'h0, reg_rdata[4]}, 32'd0);
        @(negedge clk);

        // R7 frame counter reset
        wr(32'h4);
        c0 = cyc;
        chk("R7 pulse", {30'h0, frm_rst, reg_rdata[2]}, 32'd3);
        wait_low(frm_rst);
        chk("R7 length", 32'(cyc - c0), 32'd3);
        chk("R7 bit clears", {31'h0, reg_rdata[2]}, 32'd0);

        // R8 full-speed reset
        wr(32'h2);
        repeat (5) @(negedge clk);
        chk("R8 held", {30'h0, fs_rst, reg_rdata[1]}, 32'd3);
        fs_ack = 1'b1;
        @(negedge clk);
        fs_ack = 1'b0;
        chk("R8 release", {30'h0, fs_rst, reg_rdata[1]}, 32'd0);

        // R9 core reset waits for idle bus master
        mst_idle = 1'b0;
        wr(32'h1);
        repeat (4) @(negedge clk);
        chk("R9 gated", {30'h0, core_rst, reg_rdata[0]}, 32'd1);
        mst_idle = 1'b1;
        @(negedge clk);
        // R10 flush everything while in core reset
        chk("R10 core asserted", {29'h0, core_rst, txf_flush, rxf_flush}, 32'd7);
        chk("R10 all targets", {16'h0, txf_sel}, 32'h0000_FFFF);
        repeat (3) @(negedge clk);
        chk("R10 held w/o ack", {31'h0, core_rst}, 32'd1);
        core_ack = 1'b1;
        @(negedge clk);
        core_ack = 1'b0;
        chk("R10 release", {29'h0, core_rst, txf_flush, reg_rdata[0]}, 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule